// File: doc/BRIEF.md
# Synchronized Debug Serial Port

This block is the target end of a debug serial link. An external host drives a serial clock and a serial data line. Neither is related to the core clock. The block brings both lines into the core clock domain. It accepts a serial clock level only once that level has held steady, and it acts on each accepted rising edge of the serial clock. On such an edge it takes in one command bit and moves its registered serial output on by one bit.

Command and response packets are both 17 bits long. The first bit is a status/control bit and the other 16 are data, sent most significant first. Once a whole command has arrived, the block raises a one-cycle strobe and shows the command word on a parallel output. The logic that decodes the command and performs the access then loads a response word, and that word goes out during the next packet. If no response is waiting when a packet begins, a fixed "not ready" word goes out in its place. The host must keep the serial clock at no more than one fifth of the core clock rate.

Top module: `dbg_serial_port`

## Requirements
- R1: The serial clock and serial data are synchronized to the core clock. A serial clock level counts only when it reads the same on two consecutive core clock edges, so a high pulse that lasts a single core cycle is ignored. Accepted rising edges are at least four core cycles apart.
- R2: Each accepted rising edge of the serial clock samples exactly one serial input bit. Packets are 17 bits: bit 16 (status/control) arrives first and bit 0 arrives last.
- R3: When the 17th bit of a packet is sampled, `cmd_valid_o` goes high for exactly one core cycle. `cmd_word_o` then carries the received packet, with the first received bit at bit 16. `cmd_word_o` keeps that value until the next packet completes.
- R4: `dbg_sdo_o` comes from a register and changes only on an accepted rising edge of the serial clock. On the k-th edge of a packet (k = 0..16) it takes bit 16-k of the response chosen for that packet.
- R5: If no response is pending when a packet starts (its first accepted edge), the response for that packet is the not-ready word 17'h10000: status bit 1, data zero.
- R6: A pulse of `rsp_load_i` stores `rsp_word_i` and marks it pending. The next packet to start sends it and clears the pending mark, so the packet after that sends the not-ready word unless a new word is loaded.
- R7: If `rsp_load_i` is sampled in the same core cycle as a packet's first accepted edge, that packet sends what was pending before the load (or the not-ready word). The newly loaded word stays pending for the following packet.
- R8: Synchronous reset `rst` (active high) clears the bit counter, both shift registers, the serial output (to 0), the pending mark, `cmd_valid_o` and `cmd_word_o`. The next packet then starts at bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_sclk_i | input | 1 | Asynchronous serial clock from the host |
| dbg_sdi_i | input | 1 | Asynchronous serial data from the host |
| dbg_sdo_o | output | 1 | Registered serial response data |
| rsp_load_i | input | 1 | Strobe that stores a response word as pending |
| rsp_word_i | input | 17 | Response word, bit 16 is sent first |
| cmd_valid_o | output | 1 | One-cycle strobe for a completed command |
| cmd_word_o | output | 17 | Last completed command, first bit at bit 16 |

## Verification
Two events can fall in the same core cycle: the first accepted serial edge of a packet, which selects the response and clears the pending mark, and a response load from the parallel side. The bench provokes this by counting core edges from the moment it raises the serial clock. It pulses the load strobe in exactly the cycle the synchronizer reports that edge. It then judges the result by reading the serial output over two packets: the colliding packet must carry the earlier word and the next packet the new one. A separate test drops a single-cycle glitch on the serial clock in the middle of a packet. Both the command and the response must still arrive intact.

// File: rtl/dbgsp_pkg.sv
package dbgsp_pkg;

  // Response sent when nothing is pending: status bit set, data zero.
  function automatic logic [31:0] not_ready_word(input int unsigned width);
    return 32'd1 << (width - 1);
  endfunction

  // Width of a counter that indexes 0..n-1.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/dbgsp_sync.sv
module dbgsp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_async,
  input  logic sdin_async,
  output logic sclk_rise,
  output logic sdin_sync
);
  logic [STAGES-1:0] ck_ff;
  logic [STAGES-1:0] dt_ff;
  logic              ck_hold;
  logic              ck_valid;
  logic              ck_prev;
  logic [2:0]        gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_ff    <= '0;
      dt_ff    <= '0;
      ck_hold  <= 1'b0;
      ck_valid <= 1'b0;
      ck_prev  <= 1'b0;
    end else begin
      ck_ff   <= {ck_ff[STAGES-2:0], sclk_async};
      dt_ff   <= {dt_ff[STAGES-2:0], sdin_async};
      ck_hold <= ck_ff[STAGES-1];
      if (ck_ff[STAGES-1] == ck_hold) ck_valid <= ck_ff[STAGES-1];
      ck_prev <= ck_valid;
    end
  end

  assign sclk_rise = ck_valid & ~ck_prev;
  assign sdin_sync = dt_ff[STAGES-1];

  // cycles since the last accepted rising edge, saturating
  always_ff @(posedge clk) begin
    if (rst)              gap_q <= 3'd7;
    else if (sclk_rise)   gap_q <= 3'd0;
    else if (gap_q != 3'd7) gap_q <= gap_q + 3'd1;
  end

  AST_RISE_SPACED: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |-> gap_q >= 3'd3); // R1

  AST_NO_RISE_WHEN_LOW: assert property (@(posedge clk) disable iff (rst)
    (!ck_hold && !ck_ff[STAGES-1] && !ck_valid) |=> !sclk_rise); // R1

endmodule

// File: rtl/dbgsp_shifter.sv
module dbgsp_shifter #(
  parameter int unsigned PKT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             bit_in,
  input  logic             rsp_load,
  input  logic [PKT_W-1:0] rsp_word,
  output logic             sdo,
  output logic             cmd_valid,
  output logic [PKT_W-1:0] cmd_word
);
  import dbgsp_pkg::*;

  localparam int unsigned CW = idx_width(PKT_W);
  localparam logic [CW-1:0] LAST_IDX = CW'(PKT_W - 1);
  localparam logic [31:0] NR32 = not_ready_word(PKT_W);
  localparam logic [PKT_W-1:0] NOT_READY = NR32[PKT_W-1:0];

  logic [CW-1:0]    cnt_q;
  logic [PKT_W-2:0] rx_sh;
  logic [PKT_W-1:0] tx_sh;
  logic [PKT_W-1:0] rsp_buf;
  logic             rsp_pend;

  logic             frame_start;
  logic             frame_done;
  logic [PKT_W-1:0] tx_src;
  logic [PKT_W-1:0] rx_next;

  assign frame_start = bit_stb && (cnt_q == '0);
  assign frame_done  = bit_stb && (cnt_q == LAST_IDX);
  assign tx_src      = frame_start ? (rsp_pend ? rsp_buf : NOT_READY) : tx_sh;
  assign rx_next     = {rx_sh, bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      sdo       <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (bit_stb) begin
        rx_sh <= rx_next[PKT_W-2:0];
        sdo   <= tx_src[PKT_W-1];
        tx_sh <= {tx_src[PKT_W-2:0], 1'b0};
        cnt_q <= frame_done ? '0 : cnt_q + 1'b1;
        if (frame_done) begin
          cmd_valid <= 1'b1;
          cmd_word  <= rx_next;
        end
      end
    end
  end

  // response buffer: a load lands after a coinciding frame start
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_buf  <= '0;
      rsp_pend <= 1'b0;
    end else if (rsp_load) begin
      rsp_buf  <= rsp_word;
      rsp_pend <= 1'b1;
    end else if (frame_start) begin
      rsp_pend <= 1'b0;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_IDX); // R2

  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid); // R3

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable(cmd_word)); // R3

  AST_SDO_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> $stable(sdo)); // R4

  AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !rsp_load) |=> !rsp_pend); // R6

  AST_LOAD_PENDS: assert property (@(posedge clk) disable iff (rst)
    rsp_load |=> rsp_pend); // R7

endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port #(
  parameter int unsigned PKT_W       = 17,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dbg_sclk_i,
  input  logic             dbg_sdi_i,
  output logic             dbg_sdo_o,
  input  logic             rsp_load_i,
  input  logic [PKT_W-1:0] rsp_word_i,
  output logic             cmd_valid_o,
  output logic [PKT_W-1:0] cmd_word_o
);
  logic bit_stb;
  logic bit_val;

  dbgsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .sclk_async (dbg_sclk_i),
    .sdin_async (dbg_sdi_i),
    .sclk_rise  (bit_stb),
    .sdin_sync  (bit_val)
  );

  dbgsp_shifter #(.PKT_W(PKT_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .bit_stb   (bit_stb),
    .bit_in    (bit_val),
    .rsp_load  (rsp_load_i),
    .rsp_word  (rsp_word_i),
    .sdo       (dbg_sdo_o),
    .cmd_valid (cmd_valid_o),
    .cmd_word  (cmd_word_o)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!dbg_sdo_o && !cmd_valid_o && cmd_word_o == '0)); // R8

endmodule

// File: tb/tb_dbg_serial_port.sv
module tb_dbg_serial_port;
  localparam int W = 17;
  localparam logic [W-1:0] NR = 17'h10000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sclk = 1'b0;
  logic         sdi = 1'b0;
  logic         sdo;
  logic         rsp_load = 1'b0;
  logic [W-1:0] rsp_word = '0;
  logic         cmd_valid;
  logic [W-1:0] cmd_word;

  int tests = 0;
  int fails = 0;
  int vcount = 0;
  int wide = 0;
  bit prev_v = 1'b0;
  bit done = 1'b0;
  logic [W-1:0] last_cmd = '0;

  always #2 clk = ~clk;

  dbg_serial_port dut (
    .clk(clk), .rst(rst), .dbg_sclk_i(sclk), .dbg_sdi_i(sdi), .dbg_sdo_o(sdo),
    .rsp_load_i(rsp_load), .rsp_word_i(rsp_word),
    .cmd_valid_o(cmd_valid), .cmd_word_o(cmd_word)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      vcount <= vcount + 1;
      last_cmd <= cmd_word;
      if (prev_v) wide <= wide + 1;
    end
    prev_v <= cmd_valid;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_rsp(input logic [W-1:0] w);
    @(negedge clk);
    rsp_word = w;
    rsp_load = 1'b1;
    @(negedge clk);
    rsp_load = 1'b0;
  endtask

  // one serial bit: low phase (with optional glitch), high phase, sample sdo
  task automatic clock_bit(input logic b, input bit glitch, input bit collide,
                           input logic [W-1:0] cw, output logic got);
    @(negedge clk);
    sclk = 1'b0;
    sdi  = b;
    wait_n(2);
    if (glitch) begin
      sclk = 1'b1;
      @(negedge clk);
      sclk = 1'b0;
    end
    wait_n(4);
    sclk = 1'b1;
    if (collide) begin
      wait_n(4);
      rsp_word = cw;
      rsp_load = 1'b1;
      @(negedge clk);
      rsp_load = 1'b0;
      wait_n(1);
    end else begin
      wait_n(6);
    end
    got = sdo;
  endtask

  task automatic send_frame(input logic [W-1:0] cmd, input int glitch_at,
                            input bit collide, input logic [W-1:0] cw,
                            output logic [W-1:0] rsp);
    for (int i = W - 1; i >= 0; i--) begin
      logic g;
      clock_bit(cmd[i], (i == glitch_at), (collide && i == W - 1), cw, g);
      rsp[i] = g;
    end
    @(negedge clk);
    sclk = 1'b0;
    wait_n(8);
  endtask

  task automatic t_reset_state;
    check("R8 sdo after reset", {31'd0, sdo}, 32'd0);
    check("R8 cmd_valid after reset", {31'd0, cmd_valid}, 32'd0);
    check("R8 cmd_word after reset", {15'd0, cmd_word}, 32'd0);
  endtask

  task automatic t_not_ready;
    logic [W-1:0] r;
    int v0 = vcount;
    send_frame(17'h1C3A5, -1, 1'b0, '0, r);
    check("R5 not-ready response", {15'd0, r}, {15'd0, NR});
    check("R2 command received", {15'd0, last_cmd}, 32'h1C3A5);
    check("R3 one strobe per packet", vcount - v0, 1);
    check("R3 strobe one cycle wide", wide, 0);
    check("R3 word held after strobe", {15'd0, cmd_word}, 32'h1C3A5);
  endtask

  task automatic t_response;
    logic [W-1:0] r;
    load_rsp(17'h0B6D3);
    send_frame(17'h1FFFF, -1, 1'b0, '0, r);
    check("R4 loaded response shifted out", {15'd0, r}, 32'h0B6D3);
    check("R2 all-ones command", {15'd0, last_cmd}, 32'h1FFFF);
    send_frame(17'h0AAAA, -1, 1'b0, '0, r);
    check("R6 response consumed once", {15'd0, r}, {15'd0, NR});
    check("R2 alternating command", {15'd0, last_cmd}, 32'h0AAAA);
    load_rsp(17'h15555);
    send_frame(17'h00000, -1, 1'b0, '0, r);
    check("R4 second response", {15'd0, r}, 32'h15555);
    check("R2 all-zero command", {15'd0, last_cmd}, 32'h00000);
  endtask

  task automatic t_glitch;
    logic [W-1:0] r;
    int v0 = vcount;
    load_rsp(17'h1E01F);
    send_frame(17'h12345, 8, 1'b0, '0, r);
    check("R1 glitch ignored on command", {15'd0, last_cmd}, 32'h12345);
    check("R1 glitch ignored on response", {15'd0, r}, 32'h1E01F);
    check("R1 single strobe despite glitch", vcount - v0, 1);
  endtask

  task automatic t_collide;
    logic [W-1:0] r;
    load_rsp(17'h0F0F0);
    send_frame(17'h06789, -1, 1'b1, 17'h1ABCD, r);
    check("R7 colliding packet keeps old word", {15'd0, r}, 32'h0F0F0);
    send_frame(17'h00F00, -1, 1'b0, '0, r);
    check("R7 load kept for next packet", {15'd0, r}, 32'h1ABCD);
    send_frame(17'h00001, -1, 1'b1, 17'h03333, r);
    check("R7 collide with none pending", {15'd0, r}, {15'd0, NR});
    send_frame(17'h00002, -1, 1'b0, '0, r);
    check("R7 second late load kept", {15'd0, r}, 32'h03333);
  endtask

  task automatic t_mid_reset;
    logic [W-1:0] r;
    int v0;
    load_rsp(17'h1AAAA);
    for (int i = 0; i < 8; i++) begin
      logic g;
      clock_bit(1'b1, 1'b0, 1'b0, '0, g);
    end
    @(negedge clk);
    sclk = 1'b0;
    wait_n(6);
    rst = 1'b1;
    wait_n(2);
    check("R8 sdo cleared by reset", {31'd0, sdo}, 32'd0);
    check("R8 cmd_word cleared by reset", {15'd0, cmd_word}, 32'd0);
    rst = 1'b0;
    wait_n(4);
    v0 = vcount;
    send_frame(17'h0C0DE, -1, 1'b0, '0, r);
    check("R8 counter restarts at bit 16", {15'd0, last_cmd}, 32'h0C0DE);
    check("R8 pending cleared by reset", {15'd0, r}, {15'd0, NR});
    check("R8 one strobe after reset", vcount - v0, 1);
  endtask

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    t_reset_state();
    t_not_ready();
    t_response();
    t_glitch();
    t_collide();
    t_mid_reset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule